// File: doc/BRIEF.md
# Four-Lane Interleaved Vector Arithmetic Unit

This block runs element-wise integer vector add and multiply. It has four parallel lanes. Each lane keeps its own slice of every vector register and its own two-stage execution pipeline. Element i of a register always lives in lane i mod 4, at slot i div 4. An operation therefore only ever pairs element i of one source with element i of the other source. All operand reads and result writes stay inside one lane, and the lanes share nothing but control.

An instruction gives an operation, a destination register, two source registers and a vector length. Once the unit accepts it, the sequencer walks the element groups. Group g covers elements 4g to 4g+3, one element per lane, so up to four results are written per cycle. In the final group, lanes whose element index is at or beyond the vector length are masked and write nothing. A one-cycle `done` pulse marks completion. A host element port loads and reads single register elements between instructions.

Top module: `vec_lane_unit`

## Requirements
- R1: A host write of `wr_data` to register `wr_reg`, element `wr_idx` (lane = `wr_idx[1:0]`, slot = `wr_idx[4:2]`) while idle is stored. `rd_data` shows the element addressed by `rd_reg`/`rd_idx` one cycle after that address is sampled.
- R2: With `issue_op` = 0 (add), each destination element i below the vector length becomes (src1[i] + src2[i]) mod 2^16, using only same-index elements.
- R3: With `issue_op` = 1 (multiply), each destination element i below the vector length becomes the low 16 bits of src1[i] * src2[i].
- R4: Destination elements at index vector-length or above keep their previous value, including the masked lanes of a partial final group. Every group before the last runs all four lanes.
- R5: A vector length above 32 is treated as 32.
- R6: If an instruction is accepted at clock edge 0, `done` is high for exactly one cycle, after edge G+2. G = ceil(min(vl,32)/4), and a length of 0 counts as one fully masked group.
- R7: `busy` rises after the accepting edge and is low again in the `done` cycle. An issue presented while `busy` is high is ignored. An issue presented in the `done` cycle is accepted.
- R8: Host writes presented while `busy` is high are ignored.
- R9: After reset `busy` and `done` are 0.
- R10: The destination may be one of the sources (in-place), and each element still gets the result from its own old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction present |
| issue_op | input | 1 | 0 = add, 1 = multiply |
| issue_vd | input | 3 | Destination register |
| issue_vs1 | input | 3 | First source register |
| issue_vs2 | input | 3 | Second source register |
| issue_vl | input | 6 | Vector length (elements) |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | input | 1 | Host element write strobe |
| wr_reg | input | 3 | Host write register |
| wr_idx | input | 5 | Host write element index |
| wr_data | input | 16 | Host write data |
| rd_reg | input | 3 | Host read register |
| rd_idx | input | 5 | Host read element index |
| rd_data | output | 16 | Host read data, one cycle later |

## Verification
Completion of one instruction and acceptance of the next can fall in the same cycle. The bench keeps a dependent instruction asserted on the issue inputs through the whole run of the one before it. The held instruction must be ignored while `busy` is high and accepted exactly in the `done` cycle. Its `done` must then land G+2 cycles after that edge, and its results must be built from the values the first instruction wrote, which the bench also uses as an in-place case. A single-cycle issue and a host write are also presented mid-run, and the bench checks at the read port that both had no effect.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
  typedef enum logic {
    VOP_ADD = 1'b0,
    VOP_MUL = 1'b1
  } vop_e;
endpackage

// File: rtl/vlu_seq.sv
// Group sequencer: accepts an instruction, walks element groups, masks the tail.
module vlu_seq #(
  parameter int LANES = 4,
  parameter int MVL   = 32,
  localparam int EPL  = MVL / LANES,
  localparam int GW   = (EPL > 1) ? $clog2(EPL) : 1,
  localparam int LW   = $clog2(LANES),
  localparam int VLW  = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic [VLW-1:0]   issue_vl,
  output logic             accept,
  output logic             busy,
  output logic             done,
  output logic             grp_valid,
  output logic [GW-1:0]    grp_idx,
  output logic [LANES-1:0] lane_mask
);

  logic           busy_q, active_q, s1_last_q, wb_last_q, done_q;
  logic [GW-1:0]  grp_q, last_q;
  logic [VLW-1:0] vl_q, vl_c;
  logic [GW-1:0]  last_n;

  assign accept = issue_valid && !busy_q;
  assign vl_c   = (issue_vl > VLW'(MVL)) ? VLW'(MVL) : issue_vl;
  assign last_n = (vl_c == '0) ? '0 : GW'((vl_c - 1'b1) >> LW);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      active_q  <= 1'b0;
      s1_last_q <= 1'b0;
      wb_last_q <= 1'b0;
      done_q    <= 1'b0;
      grp_q     <= '0;
      last_q    <= '0;
      vl_q      <= '0;
    end else begin
      s1_last_q <= active_q && (grp_q == last_q);
      wb_last_q <= s1_last_q;
      done_q    <= wb_last_q;
      if (wb_last_q) busy_q <= 1'b0;
      if (active_q) begin
        if (grp_q == last_q) active_q <= 1'b0;
        else grp_q <= grp_q + 1'b1;
      end
      if (accept) begin
        busy_q   <= 1'b1;
        active_q <= 1'b1;
        grp_q    <= '0;
        last_q   <= last_n;
        vl_q     <= vl_c;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    logic [VLW:0] elem;
    always_comb begin
      elem         = (VLW+1)'(grp_q) * (VLW+1)'(LANES) + (VLW+1)'(k);
      lane_mask[k] = elem < {1'b0, vl_q};
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign grp_valid = active_q;
  assign grp_idx   = grp_q;

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r7_busy_low_on_done: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  a_r7_idle_no_groups: assert property (@(posedge clk) disable iff (rst) !busy |-> !grp_valid);
  a_r4_full_groups: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && (grp_idx != last_q)) |-> (&lane_mask));
  a_r5_len_bound: assert property (@(posedge clk) disable iff (rst) busy |-> (vl_q <= VLW'(MVL)));

endmodule

// File: rtl/vlu_lane.sv
// One lane: local register slice with synchronous reads and a two-stage pipe.
module vlu_lane import vlu_pkg::*; #(
  parameter int W    = 16,
  parameter int NREG = 8,
  parameter int EPL  = 8,
  localparam int GW  = (EPL > 1) ? $clog2(EPL) : 1,
  localparam int RW  = $clog2(NREG),
  localparam int AW  = RW + GW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grp_valid,
  input  logic          lane_on,
  input  logic [GW-1:0] grp_idx,
  input  vop_e          op,
  input  logic [RW-1:0] vd,
  input  logic [RW-1:0] vs1,
  input  logic [RW-1:0] vs2,
  input  logic          host_we,
  input  logic [AW-1:0] host_waddr,
  input  logic [W-1:0]  host_wdata,
  input  logic [AW-1:0] host_raddr,
  output logic [W-1:0]  host_rdata
);

  logic [W-1:0]  mem [NREG*EPL];
  logic          s1_v;
  logic [W-1:0]  s1_a, s1_b, res;
  logic [AW-1:0] s1_wa;
  vop_e          s1_op;

  always_comb begin
    if (s1_op == VOP_MUL) res = s1_a * s1_b;
    else                  res = s1_a + s1_b;
  end

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= grp_valid && lane_on;
  end

  always_ff @(posedge clk) begin
    if (s1_v)         mem[s1_wa] <= res;
    else if (host_we) mem[host_waddr] <= host_wdata;
    s1_a       <= mem[{vs1, grp_idx}];
    s1_b       <= mem[{vs2, grp_idx}];
    s1_wa      <= {vd, grp_idx};
    s1_op      <= op;
    host_rdata <= mem[host_raddr];
  end

  a_r8_no_host_write_in_wb: assert property (@(posedge clk) disable iff (rst) !(s1_v && host_we));
  a_r4_masked_lane_quiet: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && !lane_on) |=> !s1_v);

endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit import vlu_pkg::*; #(
  parameter int W     = 16,
  parameter int LANES = 4,
  parameter int MVL   = 32,
  parameter int NREG  = 8,
  localparam int EPL  = MVL / LANES,
  localparam int GW   = (EPL > 1) ? $clog2(EPL) : 1,
  localparam int LW   = $clog2(LANES),
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(MVL),
  localparam int VLW  = $clog2(MVL + 1),
  localparam int AW   = RW + GW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           issue_valid,
  input  logic           issue_op,
  input  logic [RW-1:0]  issue_vd,
  input  logic [RW-1:0]  issue_vs1,
  input  logic [RW-1:0]  issue_vs2,
  input  logic [VLW-1:0] issue_vl,
  output logic           busy,
  output logic           done,
  input  logic           wr_en,
  input  logic [RW-1:0]  wr_reg,
  input  logic [IW-1:0]  wr_idx,
  input  logic [W-1:0]   wr_data,
  input  logic [RW-1:0]  rd_reg,
  input  logic [IW-1:0]  rd_idx,
  output logic [W-1:0]   rd_data
);

  logic             accept, grp_valid;
  logic [GW-1:0]    grp_idx;
  logic [LANES-1:0] lane_mask;
  vop_e             op_q;
  logic [RW-1:0]    vd_q, vs1_q, vs2_q;
  logic [LW-1:0]    rd_sel_q;
  logic [W-1:0]     lane_q [LANES];

  vlu_seq #(.LANES(LANES), .MVL(MVL)) u_seq (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_vl(issue_vl),
    .accept(accept), .busy(busy), .done(done), .grp_valid(grp_valid),
    .grp_idx(grp_idx), .lane_mask(lane_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= VOP_ADD;
      vd_q  <= '0;
      vs1_q <= '0;
      vs2_q <= '0;
    end else if (accept) begin
      op_q  <= vop_e'(issue_op);
      vd_q  <= issue_vd;
      vs1_q <= issue_vs1;
      vs2_q <= issue_vs2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_sel_q <= '0;
    else     rd_sel_q <= rd_idx[LW-1:0];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic wr_hit;
    assign wr_hit = wr_en && !busy && (wr_idx[LW-1:0] == LW'(k));
    vlu_lane #(.W(W), .NREG(NREG), .EPL(EPL)) u_lane (
      .clk(clk), .rst(rst), .grp_valid(grp_valid), .lane_on(lane_mask[k]),
      .grp_idx(grp_idx), .op(op_q), .vd(vd_q), .vs1(vs1_q), .vs2(vs2_q),
      .host_we(wr_hit), .host_waddr({wr_reg, wr_idx[IW-1:LW]}), .host_wdata(wr_data),
      .host_raddr({rd_reg, rd_idx[IW-1:LW]}), .host_rdata(lane_q[k])
    );
  end

  assign rd_data = lane_q[rd_sel_q];

  a_r9_idle_after_reset: assert property (@(posedge clk) $past(rst) |-> (!busy && !done));
  a_r7_accept_only_idle: assert property (@(posedge clk) disable iff (rst) accept |-> !busy);

endmodule

// File: tb/vec_lane_unit_test.sv
module vec_lane_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0, issue_op = 1'b0;
  logic [2:0]  issue_vd = '0, issue_vs1 = '0, issue_vs2 = '0;
  logic [5:0]  issue_vl = '0;
  logic        busy, done;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_reg = '0, rd_reg = '0;
  logic [4:0]  wr_idx = '0, rd_idx = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int errors = 0, checks = 0, cyc = 0;
  logic [15:0] model [8][32];
  int done_q [$];
  bit finished = 0;

  vec_lane_unit uut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_vd(issue_vd), .issue_vs1(issue_vs1), .issue_vs2(issue_vs2), .issue_vl(issue_vl),
    .busy(busy), .done(done), .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected completion cycle each time done is seen (R6, R7)
  always @(negedge clk) begin
    if (!rst && done) begin
      if (done_q.size() == 0) check(0, "R7 unexpected done", cyc, -1);
      else begin
        int e;
        e = done_q.pop_front();
        check(cyc == e, "R6 done cycle", cyc, e);
      end
    end
  end

  task automatic host_write(input int r, input int i, input logic [15:0] d, input bit take);
    wr_en = 1'b1; wr_reg = 3'(r); wr_idx = 5'(i); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    if (take) model[r][i] = d;
  endtask

  task automatic host_read(input int r, input int i, input string req);
    rd_reg = 3'(r); rd_idx = 5'(i);
    @(posedge clk); @(negedge clk);
    check(rd_data == model[r][i], req, rd_data, model[r][i]);
  endtask

  task automatic check_reg(input int r, input string req);
    for (int i = 0; i < 32; i++) host_read(r, i, req);
  endtask

  // Driver: holds the instruction until accepted, updates the model, queues done time
  task automatic issue(input bit op, input int vd, input int a, input int b, input int vl);
    bit bsy;
    int c0, eff, g;
    logic [15:0] r [32];
    issue_valid = 1'b1; issue_op = op; issue_vd = 3'(vd);
    issue_vs1 = 3'(a); issue_vs2 = 3'(b); issue_vl = 6'(vl);
    forever begin
      bsy = busy;
      @(posedge clk); @(negedge clk);
      if (!bsy) break;
    end
    issue_valid = 1'b0;
    c0 = cyc;
    eff = (vl > 32) ? 32 : vl;
    g = (eff == 0) ? 1 : (eff + 3) / 4;
    done_q.push_back(c0 + g + 2);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] p;
      p = model[a][i] * model[b][i];
      r[i] = op ? p[15:0] : model[a][i] + model[b][i];
    end
    for (int i = 0; i < eff; i++) model[vd][i] = r[i];
  endtask

  task automatic wait_idle();
    while (done_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b0, "R9 busy after reset", busy, 0);
    check(done == 1'b0, "R9 done after reset", done, 0);

    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 32; i++) begin
        logic [15:0] v;
        case (r)
          1: v = 16'(i * 3 + 1);
          2: v = (i < 4) ? 16'hFFFF - 16'(i) : 16'(i * 7 + 200);
          default: v = 16'(16'h1000 * r + i);
        endcase
        host_write(r, i, v, 1);
      end
    // R1: element-level readback across all lanes and slots
    host_read(1, 0, "R1 readback");
    host_read(2, 5, "R1 readback");
    host_read(3, 31, "R1 readback");
    host_read(6, 18, "R1 readback");

    // R2: full-length add with wraparound on the first elements
    issue(1'b0, 3, 1, 2, 32);
    wait_idle();
    check_reg(3, "R2 add");

    // R3/R4: partial final group (vl=7) multiply; elements 7.. untouched
    issue(1'b1, 4, 1, 2, 7);
    wait_idle();
    check_reg(4, "R3 R4 mul partial");

    // R4/R6: zero length writes nothing, completes as one masked group
    issue(1'b0, 5, 1, 2, 0);
    wait_idle();
    check_reg(5, "R4 zero length");

    // R5: length above 32 behaves as 32
    issue(1'b0, 5, 2, 4, 45);
    wait_idle();
    check_reg(5, "R5 clamp");

    // R7/R8: mid-run single-cycle issue and host write are both ignored
    issue(1'b1, 0, 1, 1, 32);
    @(negedge clk); @(negedge clk);
    issue_valid = 1'b1; issue_op = 1'b0; issue_vd = 3'd7;
    issue_vs1 = 3'd1; issue_vs2 = 3'd1; issue_vl = 6'd32;
    @(negedge clk);
    issue_valid = 1'b0;
    host_write(6, 9, 16'hBEEF, 0);
    wait_idle();
    check_reg(7, "R7 ignored issue");
    host_read(6, 9, "R8 ignored host write");
    check_reg(0, "R3 square");

    // R7/R10: dependent in-place instruction held until the done cycle
    issue(1'b0, 3, 1, 1, 10);
    issue(1'b1, 3, 3, 2, 12);
    wait_idle();
    check_reg(3, "R10 in-place chained");

    repeat (5) @(negedge clk);
    check(done_q.size() == 0, "R6 pending done", done_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule